// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus, in front of a byte-wide store of 4096 locations held in an internal register array. It samples the clock line and the data line, already synchronised to the system clock. From these it finds the start and stop conditions and shifts bytes in and out. It pulls the data line low through an open-drain enable, and never drives the line high.

A transaction opens with a start condition and an address byte. The first three bits of that byte must equal three pin-strapped select inputs, so eight of these blocks can share one bus. Four fixed device-type bits follow, and the direction bit comes last. A write carries a two-byte word address and then data bytes. The data bytes collect in a 32-byte page buffer, and a stop condition copies them into the array during a self-timed busy window. While that window is open, the block refuses to acknowledge its address, so a master can poll until the write has finished. A read returns bytes from the current address pointer, for as long as the master acknowledges each byte. An external lock input decides whether a buffered write may be committed.

Top module: `twowire_mem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start condition. It restarts address reception from any state, including a repeated start in the middle of a transaction. A rising data line while the clock is high is a stop condition, and it ends the transaction.
- R2: The address byte is taken MSB first as {dev_sel_i[2:0], 4'b1010, rw}, with rw=1 meaning read. On a mismatch the slave gives no acknowledge and leaves the bus released until the next start.
- R3: The slave acknowledges by pulling data low during the ninth clock of a byte. sda_oe_o only ever pulls low, and it changes only while the clock is low.
- R4: A write sends the word address as two bytes. The low four bits of the first byte form address bits 11:8 and its upper four bits are ignored. The second byte forms address bits 7:0.
- R5: A byte write stores its data byte at the word address once the stop condition has been seen.
- R6: A page write accepts any number of data bytes. Only the low five address bits advance, and they wrap inside the 32-byte page, so a later byte at the same offset replaces an earlier one. Locations in the page that received no byte keep their contents.
- R7: A committed write opens a busy window of WR_CYCLES clock cycles, starting the cycle after the stop. During the window the address byte is not acknowledged. After the window closes it is acknowledged again.
- R8: A current-address read returns the byte at the pointer. The pointer is one past the last byte accessed: after a write this stays within the page, and after a read it uses the full 12 bits.
- R9: In a sequential read, each master acknowledge leads to the next byte. The address increments over all 12 bits and wraps from 0xFFF to 0x000.
- R10: A master no-acknowledge ends the read. The slave releases the data line, and the pointer stays one past the last byte sent.
- R11: When wr_lock_i is high at the stop condition, the buffered write is discarded, the array is unchanged and no busy window opens.
- R12: After reset the data line is released, no busy window is open, and the address byte is acknowledged at once.
- R13: A write transaction that ends after its word address, with no data byte, only loads the pointer and opens no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, synchronised sample |
| sda_i | input | 1 | Bus data line, synchronised sample of the wired-AND line |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| dev_sel_i | input | 3 | Pin-strapped select bits, the first three bits of the address byte |
| wr_lock_i | input | 1 | When high at a stop condition, blocks the commit of buffered data |

## Verification
The checks assume the master keeps each low and high phase of the bus clock at least three system clocks long. They also assume the master changes the data line only while the clock is low, except when it forms a start or stop condition. The master never forms a start or stop while the slave is pulling the line low. The bench drives every bit with four-cycle quarter periods, and changes its inputs on the falling system clock edge. It issues a stop only after the slave has released the line at the end of an acknowledge slot or after a no-acknowledge. With these limits kept, the check that the enable changes only while the clock is low, and the check on the busy-window length, depend only on how the block itself behaves.

// File: rtl/tw_pkg.sv
// Shared types for the two-wire memory slave.
// Assumes: nothing beyond being compiled before the modules that use it.
package tw_pkg;

    // Transaction phases of the slave engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } tw_state_e;

endpackage

// File: rtl/tw_cond_detect.sv
// Bus event detector: finds clock edges and start/stop conditions.
// Assumes: scl_i/sda_i are already synchronised to clk; events are
// single-cycle pulses in the cycle where the new level is first seen.
module tw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    // Hold the previous line levels (idle bus is high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from old and new levels
    always_comb begin
        start_o = scl_q && scl_i && sda_q && !sda_i;
        stop_o  = scl_q && scl_i && !sda_q && sda_i;
        rise_o  = !scl_q && scl_i;
        fall_o  = scl_q && !scl_i;
    end
endmodule

// File: rtl/tw_page_buf.sv
// Page write buffer: one byte and one valid flag per page offset.
// Assumes: clear and write never occur in the same cycle.
module tw_page_buf #(
    parameter int PAGE  = 32,
    localparam int OW   = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [OW-1:0] off_i,
    input  logic [7:0]    data_i,
    input  logic [OW-1:0] rd_idx_i,
    output logic [7:0]    rd_data_o,
    output logic          rd_valid_o,
    output logic          any_o
);
    logic [7:0]      mem_q [PAGE];
    logic [PAGE-1:0] vld_q;

    // Track which offsets hold fresh data
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) vld_q <= '0;
        else if (we_i)       vld_q[off_i] <= 1'b1;
    end

    // Store received bytes; a repeated offset overwrites
    always_ff @(posedge clk) begin
        if (we_i) mem_q[off_i] <= data_i;
    end

    // Present the entry selected by the write engine
    always_comb begin
        rd_data_o  = mem_q[rd_idx_i];
        rd_valid_o = vld_q[rd_idx_i];
        any_o      = |vld_q;
    end
endmodule

// File: rtl/tw_write_engine.sv
// Self-timed write engine plus storage array. On go_i it opens a busy
// window of WR_CYCLES cycles and copies valid page-buffer entries into
// the array during its first PAGE cycles.
// Assumes: WR_CYCLES >= PAGE; go_i is only raised while not busy.
module tw_write_engine #(
    parameter int AW        = 12,
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 1250000,
    localparam int OW       = $clog2(PAGE),
    localparam int CW       = $clog2(WR_CYCLES + 1),
    localparam int DEPTH    = 1 << AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [AW-OW-1:0] page_i,
    output logic [OW-1:0]  idx_o,
    input  logic [7:0]     buf_data_i,
    input  logic           buf_valid_i,
    input  logic [AW-1:0]  raddr_i,
    output logic [7:0]     rdata_o,
    output logic           busy_o,
    output logic           we_o
);
    logic [CW-1:0]    cnt_q;
    logic [AW-OW-1:0] page_q;
    logic [7:0]       arr_q [DEPTH];

    // Busy window timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
        end else if (go_i) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
            page_q <= page_i;
        end else if (busy_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(WR_CYCLES - 1)) busy_o <= 1'b0;
        end
    end

    // Copy one page entry per cycle early in the window
    always_comb begin
        idx_o = cnt_q[OW-1:0];
        we_o  = busy_o && (cnt_q < CW'(PAGE)) && buf_valid_i;
    end

    // Array write port and asynchronous read port
    always_ff @(posedge clk) begin
        if (we_o) arr_q[{page_q, idx_o}] <= buf_data_i;
    end

    assign rdata_o = arr_q[raddr_i];
endmodule

// File: rtl/twowire_mem_slave.sv
// Two-wire bus slave fronting a byte array: address match with strap
// bits, two-byte word address, buffered page write, current and
// sequential read, acknowledge through an open-drain enable.
// Assumes: synchronised bus inputs, bus clock phases >= 3 clk cycles,
// 9 <= ADDR_W <= 16.
module twowire_mem_slave #(
    parameter int         ADDR_W     = 12,
    parameter int         PAGE_BYTES = 32,
    parameter logic [3:0] DEV_TYPE   = 4'b1010,
    parameter int         WR_CYCLES  = 1250000,
    localparam int        OFF_W      = $clog2(PAGE_BYTES),
    localparam int        HI_W       = ADDR_W - 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] dev_sel_i,
    input  logic       wr_lock_i
);
    import tw_pkg::*;

    logic start_ev, stop_ev, rise_ev, fall_ev;
    tw_state_e st_q;
    logic [7:0] sh_q, tx_q;
    logic [3:0] cnt_q;
    logic in_ack_q, rw_q, oe_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [HI_W-1:0] ahi_q;
    logic wr_busy, mem_we, dev_hit, byte_done;
    logic pb_we, pb_clr, pb_any, pb_valid, commit;
    logic [OFF_W-1:0] eng_idx;
    logic [7:0] pb_data, mem_rd;

    tw_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_o(start_ev), .stop_o(stop_ev), .rise_o(rise_ev), .fall_o(fall_ev)
    );

    // Decode buffer and commit strobes from the current phase
    always_comb begin
        dev_hit   = (sh_q[7:1] == {dev_sel_i, DEV_TYPE}) && !wr_busy;
        byte_done = fall_ev && (cnt_q == 4'd8) && !in_ack_q;
        pb_we     = (st_q == ST_WDAT) && byte_done;
        pb_clr    = (st_q == ST_DEV) && byte_done && dev_hit && !sh_q[0];
        commit    = stop_ev && (st_q == ST_WDAT) && pb_any && !wr_lock_i && !wr_busy;
    end

    tw_page_buf #(.PAGE(PAGE_BYTES)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr_i(pb_clr), .we_i(pb_we),
        .off_i(ptr_q[OFF_W-1:0]), .data_i(sh_q), .rd_idx_i(eng_idx),
        .rd_data_o(pb_data), .rd_valid_o(pb_valid), .any_o(pb_any)
    );

    tw_write_engine #(.AW(ADDR_W), .PAGE(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n), .go_i(commit), .page_i(ptr_q[ADDR_W-1:OFF_W]),
        .idx_o(eng_idx), .buf_data_i(pb_data), .buf_valid_i(pb_valid),
        .raddr_i(ptr_q), .rdata_o(mem_rd), .busy_o(wr_busy), .we_o(mem_we)
    );

    // Transaction sequencer: shift bits, acknowledge, move the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; sh_q <= '0; tx_q <= '0; cnt_q <= '0;
            in_ack_q <= 1'b0; rw_q <= 1'b0; oe_q <= 1'b0;
            ptr_q <= '0; ahi_q <= '0;
        end else if (start_ev) begin
            st_q <= ST_DEV; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
        end else if (stop_ev) begin
            st_q <= ST_IDLE; in_ack_q <= 1'b0; oe_q <= 1'b0;
        end else if (st_q == ST_RDAT) begin
            if (in_ack_q && rise_ev && sda_i) begin
                st_q <= ST_IDLE; in_ack_q <= 1'b0;
            end else if (in_ack_q && fall_ev) begin
                in_ack_q <= 1'b0; tx_q <= {mem_rd[6:0], 1'b0};
                oe_q <= ~mem_rd[7]; cnt_q <= 4'd1; ptr_q <= ptr_q + 1'b1;
            end else if (!in_ack_q && fall_ev) begin
                if (cnt_q == 4'd8) begin
                    oe_q <= 1'b0; in_ack_q <= 1'b1;
                end else begin
                    oe_q <= ~tx_q[7]; tx_q <= {tx_q[6:0], 1'b0}; cnt_q <= cnt_q + 1'b1;
                end
            end
        end else if (st_q != ST_IDLE) begin
            if (rise_ev && !in_ack_q) begin
                sh_q <= {sh_q[6:0], sda_i}; cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
                in_ack_q <= 1'b1; oe_q <= 1'b1;
                case (st_q)
                    ST_DEV: begin
                        rw_q <= sh_q[0];
                        if (!dev_hit) begin
                            st_q <= ST_IDLE; in_ack_q <= 1'b0; oe_q <= 1'b0;
                        end
                    end
                    ST_AHI:  ahi_q <= sh_q[HI_W-1:0];
                    ST_ALO:  ptr_q <= {ahi_q, sh_q};
                    default: ptr_q <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + 1'b1};
                endcase
            end else if (fall_ev && in_ack_q) begin
                in_ack_q <= 1'b0; cnt_q <= '0; oe_q <= 1'b0;
                case (st_q)
                    ST_DEV: begin
                        if (rw_q) begin
                            st_q <= ST_RDAT; tx_q <= {mem_rd[6:0], 1'b0};
                            oe_q <= ~mem_rd[7]; cnt_q <= 4'd1; ptr_q <= ptr_q + 1'b1;
                        end else begin
                            st_q <= ST_AHI;
                        end
                    end
                    ST_AHI:  st_q <= ST_ALO;
                    default: st_q <= ST_WDAT;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;
endmodule

// File: rtl/tw_slave_chk.sv
// Assertion checker for twowire_mem_slave, attached by bind.
// Assumes: bus clock phases last at least three clk cycles.
module tw_slave_chk #(
    parameter int WR_CYCLES = 1250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic              wr_busy,
    input logic              mem_we,
    input logic              wr_lock_i,
    input tw_pkg::tw_state_e st_q
);
    import tw_pkg::*;

    logic [31:0] busy_len;

    // Count cycles of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_len <= '0;
        else if (wr_busy) busy_len <= busy_len + 1;
        else              busy_len <= '0;
    end

    // R3
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> busy_len == 32'(WR_CYCLES));

    // R7
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DEV && wr_busy) |-> !sda_oe_o);

    // R5
    write_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_busy);

    // R11
    lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(!wr_lock_i));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> !sda_oe_o);
endmodule

bind twowire_mem_slave tw_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .wr_busy(wr_busy), .mem_we(mem_we), .wr_lock_i(wr_lock_i), .st_q(st_q)
);

// File: tb/twowire_mem_slave_tb.sv
module twowire_mem_slave_tb;
    localparam int WR = 400;
    localparam int Q  = 4;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, lock = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;
    int   errs = 0, checks = 0;
    logic [7:0] rb [0:3];

    always #2 clk = ~clk;

    twowire_mem_slave #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .dev_sel_i(SEL), .wr_lock_i(lock)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic qw(input int n); repeat (n) @(negedge clk); endtask

    task automatic bstart();
        sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b1; qw(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qw(Q); scl_m = 1'b1; qw(2*Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q); ack = !sda_bus; qw(Q); scl_m = 1'b0; qw(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(Q); scl_m = 1'b1; qw(Q); b[i] = sda_bus; qw(Q); scl_m = 1'b0; qw(Q);
        end
        sda_m = !mack; qw(Q); scl_m = 1'b1; qw(2*Q); scl_m = 1'b0; qw(Q); sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rw); return {SEL, 4'b1010, rw}; endfunction

    // Address phase of a write: device, high and low word-address bytes
    task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
        logic a;
        bstart(); send_byte(dev(1'b0), a); send_byte(hi, a); send_byte(lo, a);
    endtask

    task automatic write_one(input logic [11:0] a, input logic [7:0] d);
        logic k;
        addr_phase({4'h0, a[11:8]}, a[7:0]); send_byte(d, k); bstop(); qw(WR + 40);
    endtask

    task automatic poll(output logic ack);
        logic k;
        bstart(); send_byte(dev(1'b0), ack); bstop(); k = ack;
    endtask

    // Random read of n bytes (n <= 4) into rb
    task automatic read_at(input logic [11:0] a, input int n);
        logic k;
        addr_phase({4'h0, a[11:8]}, a[7:0]);
        bstart(); send_byte(dev(1'b1), k);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
        bstop();
    endtask

    task automatic read_cur(output logic [7:0] d);
        logic k;
        bstart(); send_byte(dev(1'b1), k); recv_byte(1'b0, d); bstop();
    endtask

    task automatic t_reset();
        logic a;
        chk("R12", "oe after reset", sda_oe, 1'b0);
        poll(a);
        chk("R12", "address acked after reset", a, 1'b1);
        chk("R3", "ack pulls line low", a, 1'b1);
    endtask

    task automatic t_mismatch();
        logic a, b;
        bstart(); send_byte({3'b011, 4'b1010, 1'b0}, a); send_byte(8'h00, b); bstop();
        chk("R2", "wrong select bits not acked", a, 1'b0);
        chk("R2", "bus stays released after mismatch", b, 1'b0);
        bstart(); send_byte({SEL, 4'b1011, 1'b0}, a); bstop();
        chk("R2", "wrong type bits not acked", a, 1'b0);
    endtask

    task automatic t_byte_write();
        logic a, k;
        addr_phase(8'hF1, 8'h23); send_byte(8'hA5, k); bstop();
        qw(60); poll(a);
        chk("R7", "poll refused inside busy window", a, 1'b0);
        qw(WR); poll(a);
        chk("R7", "poll acked after window", a, 1'b1);
        read_at(12'h123, 1);
        chk("R5", "byte write stored", rb[0], 8'hA5);
        chk("R4", "upper nibble of high address byte ignored", rb[0], 8'hA5);
    endtask

    task automatic t_page_write();
        logic k; logic [7:0] d;
        write_one(12'h2E2, 8'h77);
        addr_phase(8'h02, 8'hFC);
        for (int i = 0; i < 6; i++) send_byte(8'h10 + 8'(i), k);
        bstop(); qw(WR + 40);
        read_cur(d);
        chk("R8", "current read after page write", d, 8'h77);
        read_at(12'h2FC, 4);
        chk("R6", "page bytes at end of page", {rb[0], rb[1], rb[2], rb[3]}, 32'h10111213);
        read_at(12'h2E0, 3);
        chk("R6", "page offset wrap and neighbour kept", {8'h00, rb[0], rb[1], rb[2]}, 32'h00141577);
        addr_phase(8'h04, 8'h00);
        for (int i = 0; i < 34; i++) send_byte(8'h40 + 8'(i), k);
        bstop(); qw(WR + 40);
        read_at(12'h400, 3);
        chk("R6", "later byte overwrites same offset", {8'h00, rb[0], rb[1], rb[2]}, 32'h00606142);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] d;
        write_one(12'hFFF, 8'h3C); write_one(12'h000, 8'hC3); write_one(12'h001, 8'h5A);
        read_at(12'hFFF, 2);
        chk("R9", "sequential read wraps FFF to 000", {rb[0], rb[1]}, 16'h3CC3);
        chk("R10", "line released after master nack", sda_oe, 1'b0);
        read_cur(d);
        chk("R10", "pointer one past last byte sent", d, 8'h5A);
    endtask

    task automatic t_lock();
        logic a, k;
        write_one(12'h050, 8'h22);
        lock = 1'b1;
        addr_phase(8'h00, 8'h50); send_byte(8'h11, k); bstop();
        lock = 1'b0;
        poll(a);
        chk("R11", "no busy window when locked", a, 1'b1);
        read_at(12'h050, 1);
        chk("R11", "locked write discarded", rb[0], 8'h22);
    endtask

    task automatic t_addr_only();
        logic a; logic [7:0] d;
        addr_phase(8'h01, 8'h23); bstop();
        poll(a);
        chk("R13", "address-only write opens no window", a, 1'b1);
        addr_phase(8'h01, 8'h23); bstop();
        read_cur(d);
        chk("R13", "address-only write loads pointer", d, 8'hA5);
    endtask

    task automatic t_restart();
        logic a; logic [7:0] d;
        addr_phase(8'h00, 8'h50);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bstart(); send_byte(dev(1'b1), a);
        chk("R1", "repeated start mid-byte restarts address", a, 1'b1);
        recv_byte(1'b0, d); bstop();
        chk("R1", "read after repeated start", d, 8'h22);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        qw(5); rst_n = 1'b1; qw(5);
        t_reset();
        t_mismatch();
        t_byte_write();
        t_page_write();
        t_seq_wrap();
        t_lock();
        t_addr_only();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule